// File: doc/BRIEF.md
# Real-Time Base Timer with Tone Output

This block is a free-running 14-bit divide chain for timekeeping. Each cycle of the fabric clock it may advance by one step. The source of those steps is chosen by a select field. The choices are a 32.768 kHz crystal tick brought into the clock domain as a single-cycle pulse, every cycle of the system clock, or a single-cycle pulse from another timer's prescaler.

With a 32.768 kHz source, the carry out of the top bit gives a half-second event for a clock application. A second, faster event has a selectable period of 32, 128, 512 or 2048 steps, which is about 0.98 ms, 3.9 ms, 15.6 ms or 62.5 ms. Each event sets its own sticky flag, and software clears the flag.

A square-wave tone for a buzzer is taken from a low bit of the same chain, at about 4 kHz or about 2 kHz. The divider keeps its count when the source changes. A dedicated clear input returns it to zero.

Top module: `rtc_base_timer`

## Requirements
- R1: After synchronous reset, the divider holds zero and both flags and the tone output are low.
- R2: The divider advances by one only on a step from the selected source. The encoding is src_sel 0 = crystal tick pulse, 1 = every clock cycle, 2 = prescaler tick pulse, 3 = stopped. Pulses on an unselected input have no effect.
- R3: main_flag rises on the clock edge that takes the divider from 16383 to 0. When counting every cycle, this is the 16384th step after a divider clear.
- R4: fast_flag rises on the edge of the step that completes a period of 2^(5+2*fast_sel) steps. That is 32, 128, 512 or 2048 steps for fast_sel 0 to 3, counted from a divider clear.
- R5: A set flag stays high until its clear input is high on a clock edge, and it is low after that edge.
- R6: When a clear input and a new event for the same flag fall on the same edge, the flag stays high.
- R7: With buz_en high, buzz follows divider bit 2 when buz_tone is 0 and divider bit 3 when buz_tone is 1. Counting from zero, bit 2 is high for counts 4 to 7 of every 8, and bit 3 is high for counts 8 to 15 of every 16.
- R8: With buz_en low, buzz is low whatever the divider holds.
- R9: Changing src_sel does not reset or alter the divider count.
- R10: div_clr high on an edge makes the divider zero after that edge. It takes priority over a step on the same edge and leaves both flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock |
| rst | input | 1 | Synchronous active-high reset |
| src_sel | input | 2 | Step source: 0 crystal tick, 1 every cycle, 2 prescaler tick, 3 stopped |
| xtal_tick | input | 1 | Single-cycle pulse at the 32.768 kHz rate |
| pre_tick | input | 1 | Single-cycle pulse from another timer's prescaler |
| div_clr | input | 1 | Clear divider to zero |
| fast_sel | input | 2 | Fast interval: 32, 128, 512 or 2048 steps |
| buz_en | input | 1 | Tone output enable |
| buz_tone | input | 1 | 0 = bit 2 tone, 1 = bit 3 tone |
| clr_main | input | 1 | Clear main_flag |
| clr_fast | input | 1 | Clear fast_flag |
| main_flag | output | 1 | Sticky half-second overflow flag |
| fast_flag | output | 1 | Sticky fast-interval flag |
| buzz | output | 1 | Square-wave tone |

## Verification
Several properties are checked on every cycle. Each event sets its flag on the next cycle, and a flag neither rises without an event nor falls without a clear. When a clear meets an event, the set wins. A divider clear lands at zero, the divider holds whenever no step arrives, and the tone stays low while disabled. Other behaviour can only be shown by the bench's scenarios, which watch the ports. These are the exact lengths of the half-second and fast periods, which source really drives the count, that a change of source keeps the count, and the phase and rate of each tone.

// File: rtl/bt_pkg.sv
package bt_pkg;

    localparam int DIV_W     = 14;
    localparam int FAST_BASE = 4;
    localparam int FAST_STEP = 2;
    localparam int FAST_N    = 4;
    localparam int TONE_LO   = 2;

    typedef enum logic [1:0] {
        SRC_XTAL = 2'd0,
        SRC_SYS  = 2'd1,
        SRC_PRE  = 2'd2,
        SRC_OFF  = 2'd3
    } src_e;

    typedef struct packed {
        logic main_ev;
        logic fast_ev;
    } tmr_evt_t;

    function automatic int fast_tap(input int idx, input int base, input int step);
        return base + step * idx;
    endfunction

endpackage

// File: rtl/bt_tick_mux.sv
module bt_tick_mux
    import bt_pkg::*;
(
    input  logic       xtal_tick,
    input  logic       pre_tick,
    input  logic [1:0] src_sel,
    output logic       adv
);
    src_e src;
    assign src = src_e'(src_sel);

    always_comb begin
        case (src)
            SRC_XTAL: adv = xtal_tick;
            SRC_SYS:  adv = 1'b1;
            SRC_PRE:  adv = pre_tick;
            default:  adv = 1'b0;
        endcase
    end
endmodule

// File: rtl/bt_divider.sv
module bt_divider
    import bt_pkg::*;
#(
    parameter int W     = DIV_W,
    parameter int FB    = FAST_BASE,
    parameter int FS    = FAST_STEP,
    parameter int NF    = FAST_N,
    localparam int SW   = (NF > 1) ? $clog2(NF) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          adv,
    input  logic          clr,
    input  logic [SW-1:0] fast_sel,
    output logic [W-1:0]  cnt,
    output tmr_evt_t      evt
);
    logic          step;
    logic [NF-1:0] tap_evt;

    assign step = adv & ~clr;

    for (genvar i = 0; i < NF; i++) begin : g_tap
        localparam int TB = fast_tap(i, FB, FS);
        assign tap_evt[i] = step & (&cnt[TB:0]);
    end

    assign evt.main_ev = step & (&cnt);
    assign evt.fast_ev = tap_evt[fast_sel];

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (step) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/bt_flag.sv
module bt_flag (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    output logic flag
);
    always_ff @(posedge clk) begin
        if (rst) begin
            flag <= 1'b0;
        end else begin
            flag <= set | (flag & ~clr);
        end
    end
endmodule

// File: rtl/bt_tone.sv
module bt_tone (
    input  logic [1:0] tone_bits,
    input  logic       en,
    input  logic       tone_sel,
    output logic       buzz
);
    always_comb begin
        buzz = en & (tone_sel ? tone_bits[1] : tone_bits[0]);
    end
endmodule

// File: rtl/rtc_base_timer.sv
module rtc_base_timer
    import bt_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] src_sel,
    input  logic       xtal_tick,
    input  logic       pre_tick,
    input  logic       div_clr,
    input  logic [1:0] fast_sel,
    input  logic       buz_en,
    input  logic       buz_tone,
    input  logic       clr_main,
    input  logic       clr_fast,
    output logic       main_flag,
    output logic       fast_flag,
    output logic       buzz
);
    logic             adv;
    logic [DIV_W-1:0] cnt;
    tmr_evt_t         evt;
    logic [1:0]       ev_vec;
    logic [1:0]       clr_vec;
    logic [1:0]       flag_vec;

    bt_tick_mux u_mux (
        .xtal_tick (xtal_tick),
        .pre_tick  (pre_tick),
        .src_sel   (src_sel),
        .adv       (adv)
    );

    bt_divider #(
        .W  (DIV_W),
        .FB (FAST_BASE),
        .FS (FAST_STEP),
        .NF (FAST_N)
    ) u_div (
        .clk      (clk),
        .rst      (rst),
        .adv      (adv),
        .clr      (div_clr),
        .fast_sel (fast_sel),
        .cnt      (cnt),
        .evt      (evt)
    );

    assign ev_vec  = {evt.main_ev, evt.fast_ev};
    assign clr_vec = {clr_main, clr_fast};

    for (genvar k = 0; k < 2; k++) begin : g_flag
        bt_flag u_flag (
            .clk  (clk),
            .rst  (rst),
            .set  (ev_vec[k]),
            .clr  (clr_vec[k]),
            .flag (flag_vec[k])
        );
    end

    assign main_flag = flag_vec[1];
    assign fast_flag = flag_vec[0];

    bt_tone u_tone (
        .tone_bits (cnt[TONE_LO+1:TONE_LO]),
        .en        (buz_en),
        .tone_sel  (buz_tone),
        .buzz      (buzz)
    );
endmodule

// File: rtl/rtc_base_timer_chk.sv
module rtc_base_timer_chk #(
    parameter int W = 14
) (
    input logic         clk,
    input logic         rst,
    input logic         adv,
    input logic         div_clr,
    input logic         main_ev,
    input logic         fast_ev,
    input logic         clr_main,
    input logic         clr_fast,
    input logic         main_flag,
    input logic         fast_flag,
    input logic         buz_en,
    input logic         buzz,
    input logic [W-1:0] cnt
);
    AST_MAIN_SET: assert property (@(posedge clk) disable iff (rst)
        main_ev |=> main_flag); // R3
    AST_MAIN_NO_SPUR: assert property (@(posedge clk) disable iff (rst)
        !main_ev && !main_flag |=> !main_flag); // R3
    AST_FAST_SET: assert property (@(posedge clk) disable iff (rst)
        fast_ev |=> fast_flag); // R4
    AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (rst)
        main_flag && !clr_main |=> main_flag); // R5
    AST_FLAG_DROP: assert property (@(posedge clk) disable iff (rst)
        fast_flag && clr_fast && !fast_ev |=> !fast_flag); // R5
    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        clr_fast && fast_ev |=> fast_flag); // R6
    AST_BUZZ_QUIET: assert property (@(posedge clk) disable iff (rst)
        !buz_en |-> !buzz); // R8
    AST_DIV_ZERO: assert property (@(posedge clk) disable iff (rst)
        div_clr |=> (cnt == '0)); // R10
    AST_DIV_HOLD: assert property (@(posedge clk) disable iff (rst)
        !adv && !div_clr |=> $stable(cnt)); // R2
endmodule

bind rtc_base_timer rtc_base_timer_chk #(.W(bt_pkg::DIV_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .adv       (adv),
    .div_clr   (div_clr),
    .main_ev   (evt.main_ev),
    .fast_ev   (evt.fast_ev),
    .clr_main  (clr_main),
    .clr_fast  (clr_fast),
    .main_flag (main_flag),
    .fast_flag (fast_flag),
    .buz_en    (buz_en),
    .buzz      (buzz),
    .cnt       (cnt)
);

// File: tb/sim_rtc_base_timer.sv
`timescale 1ns/1ps
module sim_rtc_base_timer;
    logic       clk = 1'b0;
    logic       rst;
    logic [1:0] src_sel;
    logic       xtal_tick, pre_tick, div_clr;
    logic [1:0] fast_sel;
    logic       buz_en, buz_tone, clr_main, clr_fast;
    logic       main_flag, fast_flag, buzz;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    rtc_base_timer u0 (
        .clk(clk), .rst(rst), .src_sel(src_sel), .xtal_tick(xtal_tick),
        .pre_tick(pre_tick), .div_clr(div_clr), .fast_sel(fast_sel),
        .buz_en(buz_en), .buz_tone(buz_tone), .clr_main(clr_main),
        .clr_fast(clr_fast), .main_flag(main_flag), .fast_flag(fast_flag),
        .buzz(buzz)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_div;
        div_clr = 1'b1; tick(1); div_clr = 1'b0;
    endtask

    task automatic clear_flags;
        clr_main = 1'b1; clr_fast = 1'b1; tick(1);
        clr_main = 1'b0; clr_fast = 1'b0;
    endtask

    task automatic t_reset;
        rst = 1'b1; src_sel = 2'd3; xtal_tick = 0; pre_tick = 0; div_clr = 0;
        fast_sel = 0; buz_en = 0; buz_tone = 0; clr_main = 0; clr_fast = 0;
        tick(3);
        rst = 1'b0; buz_en = 1'b1;
        tick(1);
        chk("R1 main_flag", main_flag, 0);
        chk("R1 fast_flag", fast_flag, 0);
        chk("R1 buzz", buzz, 0);
        buz_tone = 1'b1; tick(1);
        chk("R1 buzz tone1", buzz, 0);
        buz_tone = 1'b0;
    endtask

    task automatic pulse(input bit on_xtal, input bit on_pre);
        xtal_tick = on_xtal; pre_tick = on_pre; tick(1);
        xtal_tick = 0; pre_tick = 0; tick(2);
    endtask

    task automatic t_source;
        buz_en = 1; buz_tone = 0;
        src_sel = 2'd3; clear_div;
        src_sel = 2'd0;
        for (int i = 0; i < 3; i++) begin pulse(1, 0); pulse(0, 1); end
        chk("R2 xtal 3 steps", buzz, 0);
        pulse(1, 0);
        chk("R2 xtal 4 steps", buzz, 1);
        src_sel = 2'd3; clear_div;
        src_sel = 2'd2;
        for (int i = 0; i < 3; i++) begin pulse(0, 1); pulse(1, 0); end
        chk("R2 pre 3 steps", buzz, 0);
        pulse(0, 1);
        chk("R2 pre 4 steps", buzz, 1);
        src_sel = 2'd3; clear_div;
        xtal_tick = 1; pre_tick = 1; tick(10);
        xtal_tick = 0; pre_tick = 0;
        chk("R2 stopped", buzz, 0);
    endtask

    task automatic t_main;
        src_sel = 2'd3; clear_div; clear_flags;
        src_sel = 2'd1;
        tick(16383);
        chk("R3 before wrap", main_flag, 0);
        tick(1);
        chk("R3 at wrap", main_flag, 1);
        src_sel = 2'd3;
        tick(4);
        chk("R5 main held", main_flag, 1);
        clr_main = 1; tick(1); clr_main = 0;
        chk("R5 main cleared", main_flag, 0);
    endtask

    task automatic t_fast;
        for (int s = 0; s < 4; s++) begin
            int per;
            per = 1 << (5 + 2 * s);
            src_sel = 2'd3; fast_sel = s[1:0];
            clear_div; clear_flags;
            src_sel = 2'd1;
            tick(per - 1);
            chk($sformatf("R4 sel%0d early", s), fast_flag, 0);
            tick(1);
            chk($sformatf("R4 sel%0d period", s), fast_flag, 1);
        end
    endtask

    task automatic t_set_wins;
        src_sel = 2'd3; fast_sel = 0; clear_div; clear_flags;
        src_sel = 2'd1;
        tick(32);
        chk("R6 pre set", fast_flag, 1);
        tick(31);
        clr_fast = 1; tick(1); clr_fast = 0;
        chk("R6 set wins", fast_flag, 1);
        clr_fast = 1; tick(1); clr_fast = 0;
        chk("R5 fast cleared", fast_flag, 0);
    endtask

    task automatic t_buzz;
        buz_en = 1;
        for (int t = 0; t < 2; t++) begin
            buz_tone = t[0];
            src_sel = 2'd3; clear_div;
            src_sel = 2'd1;
            for (int k = 1; k <= 20; k++) begin
                tick(1);
                chk($sformatf("R7 tone%0d k%0d", t, k), buzz, (k >> (2 + t)) & 1);
            end
        end
        buz_en = 0;
        for (int k = 0; k < 16; k++) begin
            tick(1);
            chk("R8 disabled", buzz, 0);
        end
        buz_en = 1; buz_tone = 0;
    endtask

    task automatic t_switch;
        src_sel = 2'd3; clear_div;
        src_sel = 2'd1; tick(4);
        src_sel = 2'd3; tick(3);
        src_sel = 2'd0; tick(2);
        src_sel = 2'd2; tick(2);
        chk("R9 count kept", buzz, 1);
        src_sel = 2'd1; tick(3);
        chk("R9 count 7", buzz, 1);
        tick(1);
        chk("R9 count 8", buzz, 0);
    endtask

    task automatic t_divclr;
        src_sel = 2'd3; fast_sel = 0; clear_div; clear_flags;
        src_sel = 2'd1; tick(38);
        chk("R10 flag set", fast_flag, 1);
        chk("R10 buzz at 38", buzz, 1);
        clear_div;
        chk("R10 zero", buzz, 0);
        chk("R10 flag kept", fast_flag, 1);
        tick(3);
        chk("R10 count 3", buzz, 0);
        tick(1);
        chk("R10 count 4", buzz, 1);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        t_reset;
        t_source;
        t_main;
        t_fast;
        t_set_wins;
        t_buzz;
        t_switch;
        t_divclr;
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule